// File: doc/BRIEF.md
# Multi-Format Stereo Serial Audio Port

This block is the slave side of a stereo serial audio link. An external master supplies a bit clock and a frame clock whose two levels mark the left and right channel slots. Serial samples arriving on the data input are gathered into parallel left and right words. Parallel left and right words supplied by the core are shifted out on the data output. A 2-bit format select chooses one of four framings. Input and output framings need not match: in the two right-justified formats, the input word sits at the end of its slot while the output word starts at the beginning of the slot.

The serial clocks are oversampled by the block clock, which must be synchronous to them. Each bit clock high and low period must last at least two block clock cycles, and each channel slot holds at most 64 bit clocks. On the receive side, a completed left/right pair is announced with a one-cycle strobe. On the transmit side, both parallel words are latched once per frame, when the left slot begins.

Top module: `serial_audio_port`

## Requirements
- R1: Format code 0 takes a 16-bit word, MSB first, as the last 16 bits captured before the frame clock changes. Earlier bits in the slot are ignored. The word appears on the receive ports sign-extended to 20 bits.
- R2: Format code 1 takes a 20-bit word, MSB first, as the last 20 bits captured before the frame clock changes. Earlier bits in the slot are ignored.
- R3: Format code 2 takes a 20-bit word, MSB first, starting at the first bit clock rising edge after the frame clock changes. Later bits in the slot are ignored.
- R4: Format code 3 takes a 20-bit word, MSB first, starting at the second rising edge after the frame clock changes, so the MSB comes one bit period late. The output uses the same one-bit delay.
- R5: Serial input is sampled on bit clock rising edges. The output changes only after a falling edge. In codes 0 to 2 the output word starts in the first bit period of the slot, MSB first: 16 bits for code 0 and 20 bits for codes 1 and 2.
- R6: Output bit periods that carry no word bit are driven low.
- R7: With codes 0 to 2 the left channel occupies the frame clock high level. With code 3 the left channel occupies the low level.
- R8: Slots of 16, 24 or 32 bit clocks (32, 48 or 64 per frame) all work. At 32 per frame only code 0 is valid.
- R9: After the right word of a frame is captured, rxValid is high for exactly one cycle, with rxLeft and rxRight holding that frame's pair.
- R10: txLeft and txRight are both latched when the left slot begins. Changes to them at any other point in the frame have no effect on that frame's output.
- R11: After reset, rxLeft, rxRight, rxValid and sdOut are zero. The output stays low until the first frame clock change after a full slot has been seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock that oversamples the serial clocks |
| rstN | input | 1 | Active-low synchronous reset |
| fmtSel | input | 2 | Framing select, codes 0 to 3 |
| sclkIn | input | 1 | Serial bit clock |
| frameIn | input | 1 | Frame clock selecting the channel slot |
| sdIn | input | 1 | Serial receive data |
| sdOut | output | 1 | Serial transmit data |
| txLeft | input | 20 | Left word to transmit (low 16 bits for code 0) |
| txRight | input | 20 | Right word to transmit (low 16 bits for code 0) |
| rxLeft | output | 20 | Last received left word |
| rxRight | output | 20 | Last received right word |
| rxValid | output | 1 | One-cycle strobe that a new pair is ready |

## Verification
Every legal pairing of format code and frame length is exercised, with random words mixed with directed extremes: all zeros, all ones, MSB only and MSB clear. Slot bits outside the word carry random junk. This makes it possible to tell a correctly aligned word from one shifted by a bit or taken from the wrong end of the slot. Changing the transmit words in the middle of a frame separates a once-per-frame latch from a live path. Running the same formats at 48 and 64 bit clocks per frame separates edge-relative right-justification from fixed bit counting.

// File: rtl/sap_pkg.sv
package sap_pkg;
  localparam int SAP_WIDE_W   = 20;
  localparam int SAP_NARROW_W = 16;
  localparam int SAP_MAX_SLOT = 64;
  localparam int SAP_CNT_W    = $clog2(SAP_MAX_SLOT) + 1;
  localparam int SAP_IDX_W    = $clog2(SAP_WIDE_W + 1);

  typedef enum logic [1:0] {
    FMT_RJ16  = 2'd0,
    FMT_RJ20  = 2'd1,
    FMT_LJ20  = 2'd2,
    FMT_I2S20 = 2'd3
  } sapFmt_e;

  typedef struct packed {
    logic                 shiftIn;   // bit clock rising edge: sample input
    logic                 capLeft;   // store assembled word as left
    logic                 capRight;  // store assembled word as right
    logic                 capPrev;   // word is the shift register before this bit
    logic                 wide;      // 20-bit word (else 16-bit)
    logic                 drive;     // bit clock falling edge: update output
    logic                 loadTx;    // latch both transmit words
    logic                 txRight;   // output slot is the right channel
    logic                 bitLive;   // output slot position carries a word bit
    logic [SAP_IDX_W-1:0] bitIdx;    // word bit position, 0 = MSB
  } sapStrobe_t;
endpackage

// File: rtl/sap_ctrl.sv
module sap_ctrl
  import sap_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] fmtSel,
  input  logic       sclkIn,
  input  logic       frameIn,
  output sapStrobe_t st
);
  localparam logic [SAP_CNT_W-1:0] CNT_MAX  = '1;
  localparam logic [SAP_CNT_W-1:0] LEN_WIDE = SAP_CNT_W'(SAP_WIDE_W);
  localparam logic [SAP_CNT_W-1:0] LEN_NARW = SAP_CNT_W'(SAP_NARROW_W);

  logic                 sclkQ, sclkQQ, frameQ, frameLast, haveRef;
  logic [SAP_CNT_W-1:0] cnt;

  sapFmt_e              fmt;
  logic                 rise, fall, wide, isI2s, isRj, leftLvl, chanLeft, edgeSeen;
  logic [SAP_CNT_W-1:0] wordLen, nextPos, outPos;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclkQ     <= 1'b0;
      sclkQQ    <= 1'b0;
      frameQ    <= 1'b0;
      frameLast <= 1'b0;
      haveRef   <= 1'b0;
      cnt       <= CNT_MAX;
    end else begin
      sclkQ  <= sclkIn;
      sclkQQ <= sclkQ;
      frameQ <= frameIn;
      if (rise) begin
        frameLast <= frameQ;
        haveRef   <= 1'b1;
        cnt       <= nextPos;
      end
    end
  end

  always_comb begin
    fmt      = sapFmt_e'(fmtSel);
    rise     = sclkQ & ~sclkQQ;
    fall     = ~sclkQ & sclkQQ;
    wide     = (fmt != FMT_RJ16);
    isI2s    = (fmt == FMT_I2S20);
    isRj     = (fmt == FMT_RJ16) || (fmt == FMT_RJ20);
    wordLen  = wide ? LEN_WIDE : LEN_NARW;
    leftLvl  = ~isI2s;
    chanLeft = (frameQ == leftLvl);
    edgeSeen = haveRef && (frameQ != frameLast);

    if (edgeSeen)                nextPos = '0;
    else if (cnt == CNT_MAX)     nextPos = CNT_MAX;
    else if (cnt == CNT_MAX - 1) nextPos = cnt;
    else                         nextPos = cnt + 1'b1;

    outPos = isI2s ? nextPos - 1'b1 : nextPos;

    st          = '0;
    st.wide     = wide;
    st.shiftIn  = rise;
    st.capPrev  = isRj;
    if (rise) begin
      if (isRj) begin
        st.capLeft  = edgeSeen && (cnt != CNT_MAX) && !chanLeft;
        st.capRight = edgeSeen && (cnt != CNT_MAX) && chanLeft;
      end else begin
        st.capLeft  = (nextPos == (isI2s ? wordLen : wordLen - 1'b1)) && chanLeft;
        st.capRight = (nextPos == (isI2s ? wordLen : wordLen - 1'b1)) && !chanLeft;
      end
    end
    st.drive   = fall;
    st.txRight = !chanLeft;
    st.loadTx  = fall && edgeSeen && chanLeft;
    st.bitLive = (nextPos != CNT_MAX) && !(isI2s && nextPos == '0) && (outPos < wordLen);
    st.bitIdx  = outPos[SAP_IDX_W-1:0];
  end

  // R10: the transmit latch fires at most once per slot start
  assert_load_once_R10: assert property (@(posedge clk) disable iff (!rstN)
    st.loadTx |=> !st.loadTx);

  // R9: a word is only ever stored on a bit clock rising edge
  assert_cap_on_rise_R9: assert property (@(posedge clk) disable iff (!rstN)
    (st.capLeft || st.capRight) |-> $past(sclkIn));

endmodule

// File: rtl/sap_dpath.sv
module sap_dpath
  import sap_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  sdIn,
  input  sapStrobe_t            st,
  input  logic [SAP_WIDE_W-1:0] txLeft,
  input  logic [SAP_WIDE_W-1:0] txRight,
  output logic                  sdOut,
  output logic [SAP_WIDE_W-1:0] rxLeft,
  output logic [SAP_WIDE_W-1:0] rxRight,
  output logic                  rxValid
);
  localparam int W  = SAP_WIDE_W;
  localparam int NW = SAP_NARROW_W;
  localparam logic [SAP_IDX_W-1:0] MSB_WIDE = SAP_IDX_W'(W - 1);
  localparam logic [SAP_IDX_W-1:0] MSB_NARW = SAP_IDX_W'(NW - 1);

  logic                 sdQ;
  logic [W-1:0]         shiftReg, wordFull, wordRx, holdL, holdR, curWord;
  logic [SAP_IDX_W-1:0] topBit;
  logic [1:0]           capVec;
  logic                 validQ;

  always_comb begin
    wordFull = st.capPrev ? shiftReg : {shiftReg[W-2:0], sdQ};
    wordRx   = st.wide ? wordFull : {{(W - NW){wordFull[NW-1]}}, wordFull[NW-1:0]};
    capVec   = {st.capRight, st.capLeft};
    curWord  = st.txRight ? holdR : (st.loadTx ? txLeft : holdL);
    topBit   = (st.wide ? MSB_WIDE : MSB_NARW) - st.bitIdx;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sdQ      <= 1'b0;
      shiftReg <= '0;
      validQ   <= 1'b0;
      holdL    <= '0;
      holdR    <= '0;
      sdOut    <= 1'b0;
    end else begin
      sdQ    <= sdIn;
      validQ <= st.capRight;
      if (st.shiftIn) shiftReg <= {shiftReg[W-2:0], sdQ};
      if (st.loadTx) begin
        holdL <= txLeft;
        holdR <= txRight;
      end
      if (st.drive) sdOut <= st.bitLive ? curWord[topBit] : 1'b0;
    end
  end

  for (genvar ch = 0; ch < 2; ch++) begin : g_rxChan
    logic [W-1:0] wordQ;
    always_ff @(posedge clk) begin
      if (!rstN)          wordQ <= '0;
      else if (capVec[ch]) wordQ <= wordRx;
    end
  end

  assign rxLeft  = g_rxChan[0].wordQ;
  assign rxRight = g_rxChan[1].wordQ;
  assign rxValid = validQ;

  // R9: the pair strobe never lasts longer than one cycle
  assert_valid_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> !rxValid);

  // R5: serial output only moves in the cycle after a falling-edge strobe
  assert_out_on_fall_R5: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdOut) |-> $past(st.drive));

  // R1: a 16-bit word reaches the port sign-extended
  assert_narrow_sext_R1: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && !$past(st.wide)) |-> (rxRight[W-1:NW-1] == '0 || rxRight[W-1:NW-1] == '1));

endmodule

// File: rtl/serial_audio_port.sv
module serial_audio_port
  import sap_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [1:0]            fmtSel,
  input  logic                  sclkIn,
  input  logic                  frameIn,
  input  logic                  sdIn,
  output logic                  sdOut,
  input  logic [SAP_WIDE_W-1:0] txLeft,
  input  logic [SAP_WIDE_W-1:0] txRight,
  output logic [SAP_WIDE_W-1:0] rxLeft,
  output logic [SAP_WIDE_W-1:0] rxRight,
  output logic                  rxValid
);
  sapStrobe_t st;

  sap_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .fmtSel  (fmtSel),
    .sclkIn  (sclkIn),
    .frameIn (frameIn),
    .st      (st)
  );

  sap_dpath u_dpath (
    .clk     (clk),
    .rstN    (rstN),
    .sdIn    (sdIn),
    .st      (st),
    .txLeft  (txLeft),
    .txRight (txRight),
    .sdOut   (sdOut),
    .rxLeft  (rxLeft),
    .rxRight (rxRight),
    .rxValid (rxValid)
  );
endmodule

// File: tb/serial_audio_port_tb_top.sv
module serial_audio_port_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  fmtSel = 2'd0;
  logic        sclkIn = 1'b1, frameIn = 1'b0, sdIn = 1'b0;
  logic        sdOut, rxValid;
  logic [19:0] txLeft = '0, txRight = '0, rxLeft, rxRight;

  int checks = 0, fails = 0;
  logic [19:0] expL [0:15];
  logic [19:0] expR [0:15];
  int pushIdx = 0, popIdx = 0;
  logic prevValid = 1'b0;
  bit   done = 0;

  always #2 clk = ~clk;

  serial_audio_port dut_i (
    .clk(clk), .rstN(rstN), .fmtSel(fmtSel), .sclkIn(sclkIn), .frameIn(frameIn),
    .sdIn(sdIn), .sdOut(sdOut), .txLeft(txLeft), .txRight(txRight),
    .rxLeft(rxLeft), .rxRight(rxRight), .rxValid(rxValid)
  );

  function automatic int wlen(input int fmt);
    return (fmt == 0) ? 16 : 20;
  endfunction

  function automatic logic [19:0] rxExpect(input int fmt, input logic [19:0] w);
    return (fmt == 0) ? {{4{w[15]}}, w[15:0]} : w;
  endfunction

  function automatic logic inBit(input int fmt, input int h, input int k,
                                 input logic [19:0] w, input logic junk);
    int n = wlen(fmt);
    if (fmt <= 1) return (k >= h - n) ? w[n - 1 - (k - (h - n))] : junk;
    if (fmt == 2) return (k < n) ? w[n - 1 - k] : junk;
    return (k >= 1 && k <= n) ? w[n - k] : junk;
  endfunction

  function automatic logic outBit(input int fmt, input int k, input logic [19:0] w);
    int n = wlen(fmt);
    int p = (fmt == 3) ? k - 1 : k;
    return (p >= 0 && p < n) ? w[n - 1 - p] : 1'b0;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [19:0] act, input logic [19:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one bit period: falling edge with new frame level and data, then rising edge
  task automatic slot(input logic fr, input logic b, input bit chk, input logic expOut, input string tag);
    @(negedge clk);
    sclkIn = 1'b0; frameIn = fr; sdIn = b;
    repeat (3) @(negedge clk);
    if (chk) check(sdOut == expOut, tag, 20'(sdOut), 20'(expOut));
    @(negedge clk);
    sclkIn = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic phase(input int fmt, input int h, input bit isLeft, input logic [19:0] rxW,
                       input logic [19:0] txW, input bit chk);
    logic lvl = (fmt == 3) ? ~isLeft : isLeft;
    string tag = $sformatf("R5 R6 R7 R%0d fmt%0d slot%0d", (fmt == 3) ? 4 : 10, fmt, h);
    for (int k = 0; k < h; k++)
      slot(lvl, inBit(fmt, h, k, rxW, 1'($urandom)), chk, outBit(fmt, k, txW), tag);
  endtask

  function automatic logic [19:0] pickWord(input int f, input int sel);
    case (f)
      0: return (sel == 0) ? 20'h80000 : 20'h08000;
      1: return (sel == 0) ? 20'h7FFFF : 20'h07FFF;
      2: return (sel == 0) ? 20'h00000 : 20'hFFFFF;
      default: return 20'($urandom);
    endcase
  endfunction

  task automatic runConfig(input int fmt, input int perFrame, input int frames);
    int h = perFrame / 2;
    logic [19:0] rl, rr, tl, tr;
    string rtag = (fmt == 0) ? "R1" : (fmt == 1) ? "R2" : (fmt == 2) ? "R3" : "R4";
    rstN = 1'b0; fmtSel = 2'(fmt); sclkIn = 1'b1; frameIn = (fmt == 3) ? 1'b1 : 1'b0;
    pushIdx = 0; popIdx = 0;
    repeat (4) @(negedge clk);
    check(rxValid == 0 && rxLeft == 0 && rxRight == 0 && sdOut == 0, "R11 reset state",
          rxLeft | rxRight | 20'(rxValid) | 20'(sdOut), 20'h0);
    rstN = 1'b1;
    // prelude right slot: output stays low (R11)
    phase(fmt, h, 1'b0, 20'($urandom), 20'h0, 1'b1);
    for (int f = 0; f < frames; f++) begin
      rl = pickWord(f, 0); rr = pickWord(f, 1);
      tl = pickWord((f + 2) % 4, 0) ^ 20'(f); tr = pickWord((f + 3) % 4, 1);
      txLeft = tl; txRight = tr;
      expL[pushIdx] = rxExpect(fmt, rl); expR[pushIdx] = rxExpect(fmt, rr); pushIdx++;
      phase(fmt, h, 1'b1, rl, tl, 1'b1);
      // R10: mid-frame changes must not reach the right slot output
      txLeft = 20'($urandom); txRight = 20'($urandom);
      phase(fmt, h, 1'b0, rr, tr, 1'b1);
    end
    phase(fmt, h, 1'b1, 20'($urandom), 20'h0, 1'b0);
    repeat (8) @(negedge clk);
    check(popIdx == pushIdx, $sformatf("R9 pair count %s R8 slot%0d", rtag, h),
          20'(popIdx), 20'(pushIdx));
  endtask

  always @(negedge clk) begin
    if (rstN && rxValid) begin
      string t = (fmtSel == 0) ? "R1" : (fmtSel == 1) ? "R2" : (fmtSel == 2) ? "R3" : "R4";
      check(!prevValid, "R9 strobe width", 20'(prevValid), 20'h0);
      if (popIdx < pushIdx) begin
        check(rxLeft == expL[popIdx], $sformatf("%s R7 R8 left", t), rxLeft, expL[popIdx]);
        check(rxRight == expR[popIdx], $sformatf("%s R7 R8 right", t), rxRight, expR[popIdx]);
      end else begin
        check(1'b0, "R9 unexpected strobe", 20'(popIdx), 20'(pushIdx));
      end
      popIdx++;
    end
    prevValid = rstN && rxValid;
  end

  initial begin
    void'($urandom(32'd20240611));
    runConfig(0, 32, 6);
    runConfig(0, 48, 5);
    runConfig(0, 64, 5);
    runConfig(1, 48, 5);
    runConfig(1, 64, 5);
    runConfig(2, 48, 5);
    runConfig(2, 64, 5);
    runConfig(3, 48, 5);
    runConfig(3, 64, 5);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule